// File: doc/BRIEF.md
# DRAM Strobe and Address Multiplexer

This block performs one access at a time to an asynchronous DRAM array of four banks. A requester presents a bank number, a word address, four byte-lane enables and a read/write flag. The block splits the word address into a row part and a column part and time-shares them on one 13-bit address bus. It then walks the row strobe, the column strobes and the write enable through a fixed sequence whose phase lengths are parameters counted in clock cycles.

The column strobes are split into two groups of four: one serves the even banks (0 and 2), the other the odd banks (1 and 3). In each group, bits 1:0 strobe the low 16-bit word and bits 3:2 the high 16-bit word, one bit per byte lane. After a read, the write-enable line is pulsed once while all strobes are high. This makes extended-data-out parts release the data bus. Read data is captured on the clock edge that ends the last column-strobe cycle, and a one-cycle done pulse marks the end of the access.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset `req_ready` is 1, all RAS, CAS and write-enable lines are high (inactive) and `done` is 0. A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the precharge ends, and any request presented meanwhile is ignored.
- R2: The bus `ma` carries the row, `req_addr[WADDR_W-1:COL_W]`, from the first cycle after acceptance to the end of the row-to-column delay. It carries the column, `req_addr[COL_W-1:0]` zero-extended, from the following cycle until the column strobes rise. `ma` does not change on the cycle a RAS or CAS line falls.
- R3: `ras_n[bank]` goes low in the second cycle after acceptance and is the only RAS line low. It stays low for T_RCD + 1 + T_CAS cycles.
- R4: During the CAS phase, only the group that matches the bank's parity is driven: `cas_even_n` for even banks, `cas_odd_n` for odd banks. Bit i of that group is low exactly when `req_be[i]` is 1, so bits 1:0 cover lanes 0 and 1 (low word) and bits 3:2 cover lanes 2 and 3 (high word). The other group stays all high.
- R5: CAS falls T_RCD + 1 cycles after RAS falls and stays low for T_CAS cycles. RAS and CAS rise on the same edge, and CAS is never low without RAS.
- R6: For a write, `we_n` is low from the column-drive cycle through the last CAS cycle. For a read, `we_n` is low for exactly one cycle: the first cycle after CAS rises, with all RAS and CAS lines high.
- R7: `done` is 1 for exactly one cycle, the first cycle after CAS rises. For a read, `rd_data` then holds the `dq_in` value present during the last CAS cycle.
- R8: After the done cycle the precharge lasts T_RP cycles in total, counting the done cycle, with all strobes high. `req_ready` returns to 1 right after it, so each access occupies 2 + T_RCD + T_CAS + T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_bank | input | 2 | Target bank |
| req_addr | input | WADDR_W | Word address (row above column) |
| req_be | input | 4 | Byte-lane enables |
| req_write | input | 1 | 1 = write, 0 = read |
| dq_in | input | 32 | Data from the DRAM array |
| rd_data | output | 32 | Captured read data |
| done | output | 1 | One-cycle access-complete pulse |
| ma | output | MA_W | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes, one per bank, active low |
| cas_even_n | output | 4 | Column strobes for banks 0 and 2, active low |
| cas_odd_n | output | 4 | Column strobes for banks 1 and 3, active low |
| we_n | output | 1 | Write enable and read-release pulse, active low |

## Verification
The assertions check on every cycle that the strobes are mutually consistent. At most one RAS line is low, only one CAS group is active, CAS never appears without RAS, and both rise together. The address holds on every strobe fall, the read-release pulse appears only with all strobes high, `done` never lasts two cycles, and the block is never ready while a strobe is low. Only the bench sweep can show the exact phase lengths, the byte-lane-to-CAS mapping for every bank and enable pattern, the row and column values on the bus, the captured read word, and that requests arriving mid-access are ignored.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_RAS  = 3'd2,
    S_COL  = 3'd3,
    S_CAS  = 3'd4,
    S_PRE  = 3'd5
  } seq_state_t;

  localparam int NBANK = 4;
  localparam int NLANE = 4;

  // one-hot bank select
  function automatic logic [NBANK-1:0] bank_onehot(input logic [1:0] bank);
    return NBANK'(1) << bank;
  endfunction

  // active-high CAS pattern for one group: lane i drives bit i
  function automatic logic [NLANE-1:0] cas_group(input logic [NLANE-1:0] be,
                                                 input logic            active,
                                                 input logic            odd_group,
                                                 input logic [1:0]      bank);
    if (active && (bank[0] == odd_group))
      return be;
    return '0;
  endfunction

  // number of counter bits needed to hold the largest phase length
  function automatic int cnt_bits(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val - 1'b1;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);  // R5

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             expired,
  output seq_state_t       state,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             cas_last,
  output logic             pre_first
);

  seq_state_t nxt;

  assign accept   = (state == S_IDLE) && req_valid;
  assign cas_last = (state == S_CAS) && expired;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      S_IDLE: if (req_valid) nxt = S_ROW;
      S_ROW: begin
        nxt      = S_RAS;
        load     = 1'b1;
        load_val = CNT_W'(T_RCD);
      end
      S_RAS: if (expired) nxt = S_COL;
      S_COL: begin
        nxt      = S_CAS;
        load     = 1'b1;
        load_val = CNT_W'(T_CAS);
      end
      S_CAS: if (expired) begin
        nxt      = S_PRE;
        load     = 1'b1;
        load_val = CNT_W'(T_RP);
      end
      S_PRE: if (expired) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pre_first <= 1'b0;
    end else begin
      state     <= nxt;
      pre_first <= cas_last;
    end
  end

  AST_ACCEPT_LEADS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == S_ROW));  // R1
  AST_PRE_FIRST_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_first |-> (state == S_PRE));  // R7

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int MA_W    = 13,
  parameter int COL_W   = 10,
  parameter int WADDR_W = 23
) (
  input  logic [WADDR_W-1:0] addr,
  input  logic               col_phase,
  output logic [MA_W-1:0]    ma
);

  localparam int ROW_W = WADDR_W - COL_W;

  function automatic logic [MA_W-1:0] row_of(input logic [WADDR_W-1:0] a);
    return MA_W'(a[WADDR_W-1:COL_W]);
  endfunction

  function automatic logic [MA_W-1:0] col_of(input logic [WADDR_W-1:0] a);
    return MA_W'(a[COL_W-1:0]);
  endfunction

  assign ma = col_phase ? col_of(addr) : row_of(addr);

  initial begin
    AST_ROW_FITS: assert (ROW_W <= MA_W && COL_W <= MA_W);  // R2
  end

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import dram_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_t       state,
  input  logic [1:0]       bank,
  input  logic [NLANE-1:0] be,
  input  logic             wr,
  input  logic             pre_first,
  output logic [NBANK-1:0] ras_n,
  output logic [NLANE-1:0] cas_even_n,
  output logic [NLANE-1:0] cas_odd_n,
  output logic             we_n
);

  logic ras_phase, cas_phase, col_phase;
  logic ras_any, cas_any;

  assign ras_phase = (state == S_RAS) || (state == S_COL) || (state == S_CAS);
  assign col_phase = (state == S_COL) || (state == S_CAS);
  assign cas_phase = (state == S_CAS);

  assign ras_n      = ~(ras_phase ? bank_onehot(bank) : '0);
  assign cas_even_n = ~cas_group(be, cas_phase, 1'b0, bank);
  assign cas_odd_n  = ~cas_group(be, cas_phase, 1'b1, bank);
  assign we_n       = ~((wr && col_phase) || (!wr && pre_first));

  assign ras_any = ~&ras_n;
  assign cas_any = ~&cas_even_n || ~&cas_odd_n;

  AST_ONE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ras_n));  // R3
  AST_ONE_CAS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cas_even_n) == 0) || ($countones(~cas_odd_n) == 0));  // R4
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any |-> ras_any);  // R5
  AST_RAS_CAS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cas_any) && !cas_any) |-> !ras_any);  // R5
  AST_EDO_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !cas_any && !col_phase) |-> !ras_any);  // R6

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_seq_pkg::*;
#(
  parameter int MA_W    = 13,
  parameter int COL_W   = 10,
  parameter int WADDR_W = 23,
  parameter int DATA_W  = 32,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_RP    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_bank,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [3:0]         req_be,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  dq_in,
  output logic [DATA_W-1:0]  rd_data,
  output logic               done,
  output logic [MA_W-1:0]    ma,
  output logic [3:0]         ras_n,
  output logic [3:0]         cas_even_n,
  output logic [3:0]         cas_odd_n,
  output logic               we_n
);

  localparam int CNT_W = cnt_bits(T_RCD, T_CAS, T_RP);

  seq_state_t         state;
  logic               accept, load, expired, cas_last, pre_first;
  logic [CNT_W-1:0]   load_val;
  logic [1:0]         bank_q;
  logic [WADDR_W-1:0] addr_q;
  logic [3:0]         be_q;
  logic               wr_q;
  logic               col_phase;

  // named events for the checks
  logic ev_ras_fall, ev_cas_fall, ras_any, cas_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      addr_q <= '0;
      be_q   <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      bank_q <= req_bank;
      addr_q <= req_addr;
      be_q   <= req_be;
      wr_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (cas_last && !wr_q)
      rd_data <= dq_in;
  end

  dram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  dram_seq_fsm #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .expired(expired),
    .state(state), .accept(accept), .load(load), .load_val(load_val),
    .cas_last(cas_last), .pre_first(pre_first)
  );

  assign col_phase = (state == S_COL) || (state == S_CAS);

  dram_addr_mux #(.MA_W(MA_W), .COL_W(COL_W), .WADDR_W(WADDR_W)) u_mux (
    .addr(addr_q), .col_phase(col_phase), .ma(ma)
  );

  dram_strobe_gen u_strobe (
    .clk(clk), .rst_n(rst_n), .state(state), .bank(bank_q), .be(be_q), .wr(wr_q),
    .pre_first(pre_first), .ras_n(ras_n), .cas_even_n(cas_even_n),
    .cas_odd_n(cas_odd_n), .we_n(we_n)
  );

  assign req_ready = (state == S_IDLE);
  assign done      = pre_first;

  assign ras_any     = ~&ras_n;
  assign cas_any     = ~&cas_even_n || ~&cas_odd_n;
  assign ev_ras_fall = (state == S_RAS) && (load_val == '0) && !load && ras_any;
  assign ev_cas_fall = (state == S_COL);

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ras_any && !cas_any));  // R1
  AST_MA_HOLD_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_any && !$past(ras_any)) |-> $stable(ma));  // R2
  AST_MA_HOLD_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_any && !$past(cas_any)) |-> $stable(ma));  // R2
  AST_CAS_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cas_fall |=> cas_any || (be_q == '0));  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_DONE_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ras_any && !cas_any && !req_ready));  // R8

endmodule

// File: tb/sim_dram_strobe_seq.sv
module sim_dram_strobe_seq;

  localparam int MA_W = 13, COL_W = 10, WADDR_W = 23;
  localparam int TR = 2, TC = 3, TP = 2;
  localparam int BUSY = 2 + TR + TC + TP;

  logic               clk = 1'b0, rst_n = 1'b0;
  logic               req_valid = 1'b0, req_ready;
  logic [1:0]         req_bank = '0;
  logic [WADDR_W-1:0] req_addr = '0;
  logic [3:0]         req_be = '0;
  logic               req_write = 1'b0;
  logic [31:0]        dq_in = '0, rd_data;
  logic               done, we_n;
  logic [MA_W-1:0]    ma;
  logic [3:0]         ras_n, cas_even_n, cas_odd_n;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  dram_strobe_seq #(.MA_W(MA_W), .COL_W(COL_W), .WADDR_W(WADDR_W),
                    .T_RCD(TR), .T_CAS(TC), .T_RP(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_addr(req_addr), .req_be(req_be), .req_write(req_write),
    .dq_in(dq_in), .rd_data(rd_data), .done(done), .ma(ma), .ras_n(ras_n),
    .cas_even_n(cas_even_n), .cas_odd_n(cas_odd_n), .we_n(we_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] dq_pat(input logic [31:0] seed, input int k);
    return seed ^ (32'(k) * 32'h0101_0101);
  endfunction

  task automatic chk_idle(input string tag);
    chk(tag, "req_ready", 32'(req_ready), 32'd1);
    chk(tag, "ras_n", 32'(ras_n), 32'hF);
    chk(tag, "cas_even_n", 32'(cas_even_n), 32'hF);
    chk(tag, "cas_odd_n", 32'(cas_odd_n), 32'hF);
    chk(tag, "we_n", 32'(we_n), 32'd1);
    chk(tag, "done", 32'(done), 32'd0);
  endtask

  // one access; entered and left at a falling edge of an idle cycle
  task automatic do_access(input logic [1:0] b, input logic [WADDR_W-1:0] a,
                           input logic [3:0] be, input logic wr, input logic noise,
                           input logic [31:0] seed);
    logic [MA_W-1:0] row, col;
    row = MA_W'(a[WADDR_W-1:COL_W]);
    col = MA_W'(a[COL_W-1:0]);
    req_valid = 1'b1; req_bank = b; req_addr = a; req_be = be; req_write = wr;
    @(negedge clk);
    for (int k = 0; k <= BUSY; k++) begin
      bit ras_ph, cas_ph, col_ph;
      logic [3:0] e_ras, e_ce, e_co;
      logic e_we;
      dq_in = dq_pat(seed, k);
      if (k == BUSY) begin
        chk_idle("R8");
      end else begin
        ras_ph = (k >= 1) && (k <= TR + 1 + TC);
        col_ph = (k >= TR + 1) && (k <= TR + 1 + TC);
        cas_ph = (k >= TR + 2) && (k <= TR + 1 + TC);
        e_ras = ras_ph ? ~(4'b1 << b) : 4'hF;
        e_ce  = (cas_ph && !b[0]) ? ~be : 4'hF;
        e_co  = (cas_ph &&  b[0]) ? ~be : 4'hF;
        e_we  = wr ? !col_ph : !(k == TR + 2 + TC);
        chk("R1", "req_ready busy", 32'(req_ready), 32'd0);
        chk("R2", "ma", 32'(ma), 32'(col_ph ? col : row));
        chk("R3", "ras_n", 32'(ras_n), 32'(e_ras));
        chk("R4", "cas_even_n", 32'(cas_even_n), 32'(e_ce));
        chk("R5", "cas_odd_n", 32'(cas_odd_n), 32'(e_co));
        chk("R6", "we_n", 32'(we_n), 32'(e_we));
        chk("R7", "done", 32'(done), 32'(k == TR + 2 + TC));
        if (k == TR + 2 + TC && !wr)
          chk("R7", "rd_data", rd_data, dq_pat(seed, TR + 1 + TC));
        // requests arriving mid-access must be ignored (R1)
        req_valid = noise && (k < BUSY - 1);
        req_bank = ~b; req_addr = ~a; req_be = ~be; req_write = ~wr;
        @(negedge clk);
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    for (int b = 0; b < 4; b++)
      for (int be = 0; be < 16; be++)
        for (int wr = 0; wr < 2; wr++) begin
          int idx;
          logic [WADDR_W-1:0] a;
          idx = b * 32 + be * 2 + wr;
          if (idx == 0)      a = '1;
          else if (idx == 1) a = '0;
          else               a = WADDR_W'(idx * 32'h0013_57B9 + 32'h2A5F1);
          do_access(2'(b), a, 4'(be), wr[0], idx[0] ^ idx[3],
                    32'hA500_0000 ^ 32'(idx * 32'h0001_0203));
        end
    finish_run();
  end

endmodule